// File: doc/BRIEF.md
# Substitution-Permutation Diffusion Layer

This block is a purely combinational, invertible mixing layer for data words that pass through scrambled storage. It cuts the word into independent blocks of a chosen width. On every block it runs a chosen number of identical rounds, and each round is a 4-bit S-box substitution followed by a bit permutation. Within one block, a change to any input bit then spreads to several output bits. No bit ever crosses a block boundary, so per-block integrity codes such as byte parity line up with the mixed data.

Two independent paths are provided. The forward path is applied before data is written. The inverse path is applied after read-back and restores the original word exactly. The round count may be set to zero, which turns both paths into plain wires. Zero is the default, because non-linear mixing can defeat end-to-end integrity checks that are computed over the unmixed data.

The block width defaults to 8 (intra-byte mixing) and must be at least 4. When the surrounding design uses byte parity, the block width must be 8. The data width must be a whole multiple of the block width.

Top module: `sp_diff_layer`

## Requirements
- R1: With ROUNDS = 0, fwd_out equals fwd_in and inv_out equals inv_in for every input.
- R2: One forward round replaces every full nibble of a block with its S-box value, then reverses the bits of the block. Nibble k occupies block bits 4k+3..4k, and block bit i moves to bit BLK_W-1-i.
- R3: The forward S-box maps input values 0..15 to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2 (hex). The inverse path uses the inverse mapping.
- R4: The forward path applies ROUNDS such rounds in sequence. For example, with BLK_W = 8 and ROUNDS = 2, an all-zero block becomes 8'hDD.
- R5: When inv_in carries the forward image of a word x, inv_out equals x. This holds for every x and every round count.
- R6: Each output block depends only on the input block at the same position. Changing bits of one block leaves every other output block unchanged.
- R7: When BLK_W is not a multiple of 4, the BLK_W mod 4 top bits of a block are not substituted. In each round they only take part in the bit reversal.
- R8: The forward and inverse paths are independent. fwd_out does not depend on inv_in, and inv_out does not depend on fwd_in.
- R9: The layer is combinational. Both outputs reflect the present inputs with no clock cycles of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fwd_in | input | DATA_W | Plain word entering the forward (mixing) path |
| fwd_out | output | DATA_W | Mixed word produced by the forward path |
| inv_in | input | DATA_W | Mixed word entering the inverse (unmixing) path |
| inv_out | output | DATA_W | Restored word produced by the inverse path |

## Verification
The bench builds three copies of the layer.

- The first uses a 32-bit word with 8-bit blocks and two rounds. It exercises chained rounds, the round trip and independence across four blocks.
- The second uses a 16-bit word with zero rounds. It confirms that both paths become plain wires.
- The third uses a 12-bit word with 6-bit blocks and one round. It reaches the case where the two top bits of each block bypass the S-box and are only reversed.

A table-driven reference computes the expected outputs for random and directed inputs. It finds inverse S-box values by searching the forward table.

// File: rtl/sp_diff_pkg.sv
package sp_diff_pkg;

    localparam int unsigned NIB_W = 4;

    typedef logic [NIB_W-1:0] nib_t;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } dir_e;

    // forward 4-bit substitution
    function automatic nib_t sbox_fwd(input nib_t x);
        nib_t y;
        unique case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

    // inverse 4-bit substitution
    function automatic nib_t sbox_inv(input nib_t x);
        nib_t y;
        unique case (x)
            4'h0: y = 4'h5;
            4'h1: y = 4'hE;
            4'h2: y = 4'hF;
            4'h3: y = 4'h8;
            4'h4: y = 4'hC;
            4'h5: y = 4'h1;
            4'h6: y = 4'h2;
            4'h7: y = 4'hD;
            4'h8: y = 4'hB;
            4'h9: y = 4'h4;
            4'hA: y = 4'h6;
            4'hB: y = 4'h3;
            4'hC: y = 4'h0;
            4'hD: y = 4'h7;
            4'hE: y = 4'h9;
            default: y = 4'hA;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/sp_sub_stage.sv
module sp_sub_stage
    import sp_diff_pkg::*;
#(
    parameter int unsigned BW  = 8,
    parameter dir_e        DIR = DIR_FWD
) (
    input  logic [BW-1:0] blk_in,
    output logic [BW-1:0] blk_out
);

    localparam int unsigned NNIB = BW / NIB_W;
    localparam int unsigned REM  = BW % NIB_W;

    for (genvar k = 0; k < NNIB; k++) begin : g_nib
        if (DIR == DIR_FWD) begin : g_fwd
            assign blk_out[k*NIB_W +: NIB_W] = sbox_fwd(blk_in[k*NIB_W +: NIB_W]);
        end else begin : g_inv
            assign blk_out[k*NIB_W +: NIB_W] = sbox_inv(blk_in[k*NIB_W +: NIB_W]);
        end
    end

    // bits above the last full nibble bypass substitution
    if (REM != 0) begin : g_rem
        assign blk_out[BW-1 -: REM] = blk_in[BW-1 -: REM];
    end

endmodule

// File: rtl/sp_perm_stage.sv
module sp_perm_stage #(
    parameter int unsigned BW = 8
) (
    input  logic [BW-1:0] blk_in,
    output logic [BW-1:0] blk_out
);

    // bit reversal: self-inverse permutation
    for (genvar i = 0; i < BW; i++) begin : g_bit
        assign blk_out[i] = blk_in[BW-1-i];
    end

endmodule

// File: rtl/sp_block.sv
module sp_block
    import sp_diff_pkg::*;
#(
    parameter int unsigned BW     = 8,
    parameter int unsigned ROUNDS = 0,
    parameter dir_e        DIR    = DIR_FWD
) (
    input  logic [BW-1:0] blk_in,
    output logic [BW-1:0] blk_out
);

    logic [BW-1:0] stg [ROUNDS+1];

    assign stg[0] = blk_in;

    for (genvar r = 0; r < ROUNDS; r++) begin : g_rnd
        logic [BW-1:0] mid;
        if (DIR == DIR_FWD) begin : g_fwd
            // substitute, then permute
            sp_sub_stage #(.BW(BW), .DIR(DIR_FWD)) u_sub (
                .blk_in  (stg[r]),
                .blk_out (mid)
            );
            sp_perm_stage #(.BW(BW)) u_perm (
                .blk_in  (mid),
                .blk_out (stg[r+1])
            );
        end else begin : g_inv
            // undo permutation, then undo substitution
            sp_perm_stage #(.BW(BW)) u_perm (
                .blk_in  (stg[r]),
                .blk_out (mid)
            );
            sp_sub_stage #(.BW(BW), .DIR(DIR_INV)) u_sub (
                .blk_in  (mid),
                .blk_out (stg[r+1])
            );
        end
    end

    assign blk_out = stg[ROUNDS];

endmodule

// File: rtl/sp_diff_layer.sv
module sp_diff_layer
    import sp_diff_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned BLK_W  = 8,
    parameter int unsigned ROUNDS = 0
) (
    input  logic [DATA_W-1:0] fwd_in,
    output logic [DATA_W-1:0] fwd_out,
    input  logic [DATA_W-1:0] inv_in,
    output logic [DATA_W-1:0] inv_out
);

    localparam int unsigned NBLK  = DATA_W / BLK_W;
    localparam int unsigned SPARE = DATA_W - NBLK * BLK_W;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        sp_block #(.BW(BLK_W), .ROUNDS(ROUNDS), .DIR(DIR_FWD)) u_fwd (
            .blk_in  (fwd_in [b*BLK_W +: BLK_W]),
            .blk_out (fwd_out[b*BLK_W +: BLK_W])
        );
        sp_block #(.BW(BLK_W), .ROUNDS(ROUNDS), .DIR(DIR_INV)) u_inv (
            .blk_in  (inv_in [b*BLK_W +: BLK_W]),
            .blk_out (inv_out[b*BLK_W +: BLK_W])
        );
    end

    // a partial top block is left unmixed
    if (SPARE != 0) begin : g_spare
        assign fwd_out[DATA_W-1 -: SPARE] = fwd_in[DATA_W-1 -: SPARE];
        assign inv_out[DATA_W-1 -: SPARE] = inv_in[DATA_W-1 -: SPARE];
    end

endmodule

// File: rtl/sp_diff_layer_chk.sv
module sp_diff_layer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ROUNDS = 0
) (
    input logic [DATA_W-1:0] fwd_in,
    input logic [DATA_W-1:0] fwd_out,
    input logic [DATA_W-1:0] inv_in,
    input logic [DATA_W-1:0] inv_out
);

    logic known;
    assign known = !$isunknown(fwd_in) && !$isunknown(inv_in);

    always_comb begin
        if (known && (inv_in == fwd_out)) begin
            // R5
            roundtrip_chk: assert (inv_out == fwd_in)
                else $error("inverse did not restore forward input");
        end
        if (known && (fwd_in == inv_out)) begin
            // R5
            reimage_chk: assert (fwd_out == inv_in)
                else $error("forward image of restored word mismatches");
        end
    end

    if (ROUNDS == 0) begin : g_pass
        always_comb begin
            if (known) begin
                // R1
                fwd_pass_chk: assert (fwd_out == fwd_in)
                    else $error("forward path not transparent");
                // R1
                inv_pass_chk: assert (inv_out == inv_in)
                    else $error("inverse path not transparent");
            end
        end
    end

endmodule

bind sp_diff_layer sp_diff_layer_chk #(
    .DATA_W (DATA_W),
    .ROUNDS (ROUNDS)
) u_chk (
    .fwd_in  (fwd_in),
    .fwd_out (fwd_out),
    .inv_in  (inv_in),
    .inv_out (inv_out)
);

// File: tb/sp_diff_layer_tb.sv
`timescale 1ns/1ps
module sp_diff_layer_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    int checks = 0;
    int errors = 0;

    int SB [16] = '{12, 5, 6, 11, 9, 0, 10, 13, 3, 14, 15, 8, 4, 7, 1, 2};

    // DUT A: 32-bit, 8-bit blocks, 2 rounds
    logic [31:0] a_fi = '0, a_ii = '0;
    logic [31:0] a_fo, a_io;
    // DUT B: 16-bit, 8-bit blocks, 0 rounds
    logic [15:0] b_fi = '0, b_ii = '0;
    logic [15:0] b_fo, b_io;
    // DUT C: 12-bit, 6-bit blocks, 1 round
    logic [11:0] c_fi = '0, c_ii = '0;
    logic [11:0] c_fo, c_io;

    sp_diff_layer #(.DATA_W(32), .BLK_W(8), .ROUNDS(2)) u_dut (
        .fwd_in(a_fi), .fwd_out(a_fo), .inv_in(a_ii), .inv_out(a_io));
    sp_diff_layer #(.DATA_W(16), .BLK_W(8), .ROUNDS(0)) u_dut_b (
        .fwd_in(b_fi), .fwd_out(b_fo), .inv_in(b_ii), .inv_out(b_io));
    sp_diff_layer #(.DATA_W(12), .BLK_W(6), .ROUNDS(1)) u_dut_c (
        .fwd_in(c_fi), .fwd_out(c_fo), .inv_in(c_ii), .inv_out(c_io));

    function automatic int inv_sb(int v);
        for (int i = 0; i < 16; i++) if (SB[i] == v) return i;
        return 0;
    endfunction

    function automatic longint unsigned rev_bits(longint unsigned x, int bw);
        longint unsigned y = 0;
        for (int i = 0; i < bw; i++) if (x[i]) y[bw-1-i] = 1'b1;
        return y;
    endfunction

    function automatic longint unsigned subst(longint unsigned x, int bw, bit inv);
        longint unsigned y = x;
        for (int k = 0; k < bw / 4; k++) begin
            int n = int'((x >> (4*k)) & 64'hF);
            int m = inv ? inv_sb(n) : SB[n];
            y = (y & ~(64'hF << (4*k))) | (longint'(m) << (4*k));
        end
        return y;
    endfunction

    function automatic longint unsigned ref_path(longint unsigned d, int dw, int bw,
                                                 int rounds, bit inv);
        longint unsigned res = 0;
        longint unsigned msk = (64'd1 << bw) - 1;
        for (int b = 0; b < dw / bw; b++) begin
            longint unsigned blk = (d >> (b*bw)) & msk;
            for (int r = 0; r < rounds; r++) begin
                if (!inv) blk = rev_bits(subst(blk, bw, 1'b0), bw);
                else      blk = subst(rev_bits(blk, bw), bw, 1'b1);
            end
            res |= blk << (b*bw);
        end
        return res;
    endfunction

    task automatic check(string req, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        check("R2 R4 A fwd", a_fo, ref_path(a_fi, 32, 8, 2, 1'b0));
        check("R3 R5 A inv", a_io, ref_path(a_ii, 32, 8, 2, 1'b1));
        check("R1 B fwd", b_fo, b_fi);
        check("R1 B inv", b_io, b_ii);
        check("R7 C fwd", c_fo, ref_path(c_fi, 12, 6, 1, 1'b0));
        check("R7 C inv", c_io, ref_path(c_ii, 12, 6, 1, 1'b1));
    endtask

    initial begin
        #(4ns * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint unsigned saved;
        @(negedge clk);
        // R4: all-zero block, two rounds -> 8'hDD
        check("R4 zero word", a_fo, 64'hDDDDDDDD);
        // R9: outputs follow inputs immediately (combinational)
        a_fi = 32'h0000_0001; #0.5;
        check("R9 same-cycle update", a_fo, ref_path(64'h1, 32, 8, 2, 1'b0));
        // R2: single round on 6-bit block, value 0 -> S gives 0x0C, reversed 6 bits = 0x0C
        c_fi = '0; #0.5;
        check("R2 R7 C zero", c_fo, 64'h30C);
        // R5: inverse of forward image restores x
        for (int i = 0; i < 20; i++) begin
            logic [31:0] x = $urandom;
            a_ii = 32'(ref_path(x, 32, 8, 2, 1'b0)); #0.5;
            check("R5 roundtrip", a_io, x);
        end
        // R6: change block 2 only; other blocks unchanged
        a_fi = 32'h1234_5678; #0.5;
        saved = a_fo;
        a_fi = 32'h12FF_5678; #0.5;
        check("R6 block isolation", a_fo & 64'hFF00FFFF, saved & 64'hFF00FFFF);
        // R8: changing inv_in leaves fwd_out; changing fwd_in leaves inv_out
        saved = a_fo;
        a_ii = 32'hDEAD_BEEF; #0.5;
        check("R8 fwd unaffected", a_fo, saved);
        saved = a_io;
        a_fi = 32'hCAFE_F00D; #0.5;
        check("R8 inv unaffected", a_io, saved);

        // per-clock random comparison against the reference model
        for (int cyc = 0; cyc < 300; cyc++) begin
            @(posedge clk); #1;
            a_fi = $urandom; a_ii = $urandom;
            b_fi = 16'($urandom); b_ii = 16'($urandom);
            c_fi = 12'($urandom); c_ii = 12'($urandom);
            @(negedge clk);
            compare_all();
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule